// File: doc/BRIEF.md
# BCD calendar clock counter

This block keeps wall-clock time and date as packed BCD bytes: seconds, minutes, hours, a week-day digit with a 2-bit leap-year counter and two leap-control bits, day of month, month and a two-digit year. It advances by one second for each accepted pulse on its tick input, which comes from an external divider. The pulse is gated by a clock-stop input. A busy output frames each advance, so that a reader can avoid sampling while digits ripple. The advance lands a fixed number of cycles after the tick, and busy stays high for a short tail after it.

Each byte has its own write strobe on a shared wide data bus. A clock-adjust strobe rounds the time to the nearest minute. The hour byte carries its own 12/24-hour mode bit and PM flag, so the mode travels with the stored value. Bus decoding, timing-pulse generation and the oscillator are outside this block.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset, seconds, minutes, hour, week byte and year read 0x00, day and month read 0x01, and busy is low.
- R2: Seconds and minutes count in BCD from 0x00 to 0x59. The step past 0x59 returns to 0x00 and carries into the next byte.
- R3: With hour bit 7 = 0 (24-hour mode), hours count 0x00 to 0x23 with bit 6 (PM) held at 0. The step past 0x23 returns to 0x00 and advances the day.
- R4: With hour bit 7 = 1 (12-hour mode), the hour byte steps 0x92, 0x81..0x91, 0xD2, 0xC1..0xD1 and back to 0x92. Bit 6 toggles on the step from hour 11 to hour 12. The day advances only on the step from 0xD1 to 0x92.
- R5: Day of month runs from 0x01 to 0x31 in months 01, 03, 05, 07, 08, 10 and 12, and to 0x30 in months 04, 06, 09 and 11. Month runs 0x01 to 0x12 and year runs 0x00 to 0x99, each carrying into the next byte on wrap.
- R6: February ends at 0x29 when week-byte bit 7 is 0 and the leap counter (week-byte bits 5:4) is 0. Otherwise it ends at 0x28; week-byte bit 7 = 1 disables leap years.
- R7: The week-day digit (week-byte bits 2:0) advances together with the day of month, from 0 to 6, and wraps to 0. Bit 3 reads 0.
- R8: A write to the year byte loads the leap counter with the year modulo 4. A week-byte write updates bits 5:4 only when the written bit 6 is 1. The leap counter increments modulo 4 on every year advance.
- R9: While the clock-stop input is high, a tick is ignored: busy stays low and no byte changes.
- R10: A clock-adjust pulse sets seconds to 0x00. When seconds were 0x30 or more, it also carries into minutes and every higher byte. Below 0x30, the higher bytes are unchanged.
- R11: An accepted tick raises busy on the next cycle. The bytes change 15 cycles after busy rises (BUSY_LEAD), and busy stays high for 1 more cycle (BUSY_TRAIL).
- R12: A byte written in the same cycle as a pending advance takes the written value. The other bytes still advance, using the carries computed from the values held before that cycle.
- R13: A byte holding a value above its legal range wraps to its lowest legal value on its next advance and carries onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (one cycle of the 32.768 kHz time base) |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse per second from the divider |
| clk_stop | input | 1 | High blocks the tick |
| clk_adjust | input | 1 | One-cycle pulse: round to the nearest minute |
| wr_en | input | 7 | Per-byte write strobe (0 sec, 1 min, 2 hour, 3 week, 4 day, 5 month, 6 year) |
| wr_data | input | 56 | Write data, byte i in bits 8i+7:8i |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hour byte with mode and PM flags |
| wk_o | output | 8 | Leap control (7:6), leap counter (5:4), week day (2:0) |
| day_o | output | 8 | Day of month, BCD |
| mon_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year, BCD |
| busy_o | output | 1 | High around each advance |

## Verification
The case that needs care is a byte write that lands in the very cycle the pending advance commits. The bench counts cycles from an accepted tick to the commit edge, then drives a seconds write into that cycle while seconds hold 0x59. The write must win for the seconds byte, and minutes must still take the carry computed from the old 0x59. The pairing of clock-adjust with a rollover is also checked end to end: an adjust at 23:59:45 on the last day of a year must produce the first instant of the next year, including the leap counter and week-day steps.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
   localparam int NUM_BYTES = 7;
   localparam int BYTE_W    = 8;
   localparam int NUM_PAIRS = 5;

   // byte slots on the write bus and in the register set
   localparam int B_SEC  = 0;
   localparam int B_MIN  = 1;
   localparam int B_HOUR = 2;
   localparam int B_WK   = 3;
   localparam int B_DAY  = 4;
   localparam int B_MON  = 5;
   localparam int B_YEAR = 6;

   // plain BCD pairs, in carry order
   localparam int P_SEC  = 0;
   localparam int P_MIN  = 1;
   localparam int P_DAY  = 2;
   localparam int P_MON  = 3;
   localparam int P_YEAR = 4;

   // BCD increment of a two-digit value, no range check
   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      logic [3:0] hi;
      if (v[3:0] >= 4'd9) begin
         hi = v[7:4] + 4'd1;
         return {hi, 4'h0};
      end
      return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // (10*T + U) mod 4 equals (2*T + U) mod 4
   function automatic logic [1:0] bcd_mod4(input logic [7:0] v);
      return {v[4], 1'b0} + v[1:0];
   endfunction
endpackage

// File: rtl/rtc_bcd_pair.sv
module rtc_bcd_pair
   import rtc_cal_pkg::*;
#(
   parameter logic [7:0] RST_VAL = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [7:0] wr_val,
   input  logic       clr,
   input  logic       step,
   input  logic [7:0] max_val,
   input  logic [7:0] min_val,
   output logic [7:0] q,
   output logic       carry
);
   logic wrap;

   // any value at or above the limit wraps, so illegal contents recover
   assign wrap  = (q >= max_val);
   assign carry = step & wrap;

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= RST_VAL;
      else if (wr)
         q <= wr_val;
      else if (clr)
         q <= 8'h00;
      else if (step)
         q <= wrap ? min_val : bcd_inc(q);
   end
endmodule

// File: rtl/rtc_hour_unit.sv
module rtc_hour_unit
   import rtc_cal_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [7:0] wr_val,
   input  logic       step,
   output logic [7:0] q,
   output logic       carry
);
   logic [5:0] h;
   logic       mode12;
   logic       pm;
   logic [7:0] inc8;
   logic [7:0] nxt;

   assign h      = q[5:0];
   assign mode12 = q[7];
   assign pm     = q[6];
   assign inc8   = bcd_inc({2'b00, h});

   always_comb begin
      nxt   = q;
      carry = 1'b0;
      if (step) begin
         if (!mode12) begin
            if (h >= 6'h23) begin
               nxt   = 8'h00;
               carry = 1'b1;
            end else begin
               nxt = {2'b00, inc8[5:0]};
            end
         end else if (h >= 6'h12) begin
            nxt = {1'b1, pm, 6'h01};
         end else if (h == 6'h11) begin
            nxt   = {1'b1, ~pm, 6'h12};
            carry = pm;
         end else begin
            nxt = {1'b1, pm, inc8[5:0]};
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= 8'h00;
      else if (wr)
         q <= wr_val;
      else
         q <= nxt;
   end
endmodule

// File: rtl/rtc_week_unit.sv
module rtc_week_unit
   import rtc_cal_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [7:0] wr_val,
   input  logic       year_wr,
   input  logic [7:0] year_val,
   input  logic       day_step,
   input  logic       year_step,
   output logic [7:0] q,
   output logic       leap_now
);
   logic [1:0] ctl;
   logic [1:0] leap;
   logic [2:0] dow;

   assign q        = {ctl, leap, 1'b0, dow};
   assign leap_now = ~ctl[1] & (leap == 2'd0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl  <= 2'b00;
         leap <= 2'd0;
         dow  <= 3'd0;
      end else begin
         if (wr)
            ctl <= wr_val[7:6];

         if (wr && wr_val[6])
            leap <= wr_val[5:4];
         else if (year_wr)
            leap <= bcd_mod4(year_val);
         else if (year_step)
            leap <= leap + 2'd1;

         if (wr)
            dow <= wr_val[2:0];
         else if (day_step)
            dow <= (dow >= 3'd6) ? 3'd0 : dow + 3'd1;
      end
   end
endmodule

// File: rtl/rtc_tick_sched.sv
module rtc_tick_sched #(
   parameter int BUSY_LEAD  = 15,
   parameter int BUSY_TRAIL = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic stop,
   output logic adv,
   output logic busy
);
   localparam int TOTAL = BUSY_LEAD + BUSY_TRAIL;
   localparam int CW    = $clog2(TOTAL + 1);

   logic [CW-1:0] cnt;

   assign busy = (cnt != '0);
   assign adv  = (cnt == CW'(BUSY_TRAIL + 1));

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
      else if (tick && !stop)
         cnt <= CW'(TOTAL);
   end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
   import rtc_cal_pkg::*;
#(
   parameter int         BUSY_LEAD  = 15,
   parameter int         BUSY_TRAIL = 1,
   parameter logic [7:0] RST_DAY    = 8'h01,
   parameter logic [7:0] RST_MON    = 8'h01
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sec_tick,
   input  logic        clk_stop,
   input  logic        clk_adjust,
   input  logic [6:0]  wr_en,
   input  logic [55:0] wr_data,
   output logic [7:0]  sec_o,
   output logic [7:0]  min_o,
   output logic [7:0]  hour_o,
   output logic [7:0]  wk_o,
   output logic [7:0]  day_o,
   output logic [7:0]  mon_o,
   output logic [7:0]  year_o,
   output logic        busy_o
);
   localparam int PAIR_BYTE [NUM_PAIRS] = '{B_SEC, B_MIN, B_DAY, B_MON, B_YEAR};

   if (BUSY_LEAD < 1) begin : g_bad_lead
      $error("BUSY_LEAD must be at least 1");
   end
   if (BUSY_TRAIL < 0) begin : g_bad_trail
      $error("BUSY_TRAIL must not be negative");
   end

   logic                 adv;
   logic                 adj_carry;
   logic                 hour_carry;
   logic                 leap_now;
   logic [NUM_PAIRS-1:0] p_step;
   logic [NUM_PAIRS-1:0] p_clr;
   logic [NUM_PAIRS-1:0] p_carry;
   logic [7:0]           p_q   [NUM_PAIRS];
   logic [7:0]           p_max [NUM_PAIRS];
   logic [7:0]           p_min [NUM_PAIRS];
   logic [7:0]           day_max;

   rtc_tick_sched #(
      .BUSY_LEAD (BUSY_LEAD),
      .BUSY_TRAIL(BUSY_TRAIL)
   ) u_sched (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (sec_tick),
      .stop (clk_stop),
      .adv  (adv),
      .busy (busy_o)
   );

   // rounding to the minute carries only from the upper half
   assign adj_carry = clk_adjust & (p_q[P_SEC] >= 8'h30);

   always_comb begin
      unique case (p_q[P_MON])
         8'h02:                      day_max = leap_now ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: day_max = 8'h30;
         default:                    day_max = 8'h31;
      endcase
   end

   always_comb begin
      p_step[P_SEC]  = adv & ~clk_adjust;
      p_step[P_MIN]  = p_carry[P_SEC] | adj_carry;
      p_step[P_DAY]  = hour_carry;
      p_step[P_MON]  = p_carry[P_DAY];
      p_step[P_YEAR] = p_carry[P_MON];

      p_clr          = '0;
      p_clr[P_SEC]   = clk_adjust;

      p_max[P_SEC]  = 8'h59;  p_min[P_SEC]  = 8'h00;
      p_max[P_MIN]  = 8'h59;  p_min[P_MIN]  = 8'h00;
      p_max[P_DAY]  = day_max; p_min[P_DAY] = 8'h01;
      p_max[P_MON]  = 8'h12;  p_min[P_MON]  = 8'h01;
      p_max[P_YEAR] = 8'h99;  p_min[P_YEAR] = 8'h00;
   end

   for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
      localparam int         BI  = PAIR_BYTE[g];
      localparam logic [7:0] RV  = (g == P_DAY) ? RST_DAY :
                                   (g == P_MON) ? RST_MON : 8'h00;
      rtc_bcd_pair #(
         .RST_VAL(RV)
      ) u_pair (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr     (wr_en[BI]),
         .wr_val (wr_data[BYTE_W*BI +: BYTE_W]),
         .clr    (p_clr[g]),
         .step   (p_step[g]),
         .max_val(p_max[g]),
         .min_val(p_min[g]),
         .q      (p_q[g]),
         .carry  (p_carry[g])
      );
   end

   rtc_hour_unit u_hour (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr_en[B_HOUR]),
      .wr_val(wr_data[BYTE_W*B_HOUR +: BYTE_W]),
      .step  (p_carry[P_MIN]),
      .q     (hour_o),
      .carry (hour_carry)
   );

   rtc_week_unit u_week (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (wr_en[B_WK]),
      .wr_val   (wr_data[BYTE_W*B_WK +: BYTE_W]),
      .year_wr  (wr_en[B_YEAR]),
      .year_val (wr_data[BYTE_W*B_YEAR +: BYTE_W]),
      .day_step (hour_carry),
      .year_step(p_carry[P_MON]),
      .q        (wk_o),
      .leap_now (leap_now)
   );

   assign sec_o  = p_q[P_SEC];
   assign min_o  = p_q[P_MIN];
   assign day_o  = p_q[P_DAY];
   assign mon_o  = p_q[P_MON];
   assign year_o = p_q[P_YEAR];
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk #(
   parameter int BUSY_LEAD  = 15,
   parameter int BUSY_TRAIL = 1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       clk_stop,
   input logic       clk_adjust,
   input logic [6:0] wr_en,
   input logic [7:0] wr_sec,
   input logic [7:0] sec_o,
   input logic [7:0] hour_o,
   input logic [2:0] dow,
   input logic       busy_o
);
   localparam int TOTAL = BUSY_LEAD + BUSY_TRAIL;

   logic [15:0] busy_len;

   always_ff @(posedge clk) begin
      if (!rst_n)
         busy_len <= '0;
      else if (busy_o)
         busy_len <= busy_len + 16'd1;
      else
         busy_len <= '0;
   end

   // R11
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (busy_len == 16'(TOTAL)));

   // R11
   sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !clk_adjust && !wr_en[0]) |=> $stable(sec_o));

   // R3
   pm24_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hour_o[7] && !hour_o[6] && !wr_en[2]) |=> !hour_o[6]);

   // R7
   dow_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dow <= 3'd6 && !wr_en[3]) |=> (dow <= 3'd6));

   // R9
   stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && clk_stop) |=> !busy_o);

   // R10
   adjust_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_adjust && !wr_en[0]) |=> (sec_o == 8'h00));

   // R12
   write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[0] |=> (sec_o == $past(wr_sec)));
endmodule

bind rtc_calendar_core rtc_calendar_chk #(
   .BUSY_LEAD (BUSY_LEAD),
   .BUSY_TRAIL(BUSY_TRAIL)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clk_stop  (clk_stop),
   .clk_adjust(clk_adjust),
   .wr_en     (wr_en),
   .wr_sec    (wr_data[7:0]),
   .sec_o     (sec_o),
   .hour_o    (hour_o),
   .dow       (wk_o[2:0]),
   .busy_o    (busy_o)
);

// File: tb/sim_rtc_calendar_core.sv
module sim_rtc_calendar_core;
   localparam int CLK_PERIOD = 10;
   localparam int LEAD       = 15;
   localparam int NV         = 17;

   // byte order in each word: year, month, day, week, hour, minute, second
   localparam logic [55:0] VIN [NV] = '{
      56'h24_05_10_03_10_20_05, 56'h24_05_10_03_10_20_59,
      56'h99_12_31_36_23_59_59, 56'h24_02_28_02_23_59_59,
      56'h24_02_28_82_23_59_59, 56'h24_02_29_05_23_59_59,
      56'h23_02_28_30_23_59_59, 56'h23_04_30_31_23_59_59,
      56'h23_01_30_36_23_59_59, 56'h24_05_10_01_91_59_59,
      56'h24_05_10_01_D1_59_59, 56'h24_05_10_01_92_59_59,
      56'h24_05_10_01_D2_59_59, 56'h24_05_10_01_89_59_59,
      56'h24_05_10_01_09_59_59, 56'h24_05_10_01_10_20_7A,
      56'h23_04_35_30_23_59_59
   };
   localparam logic [55:0] VEXP [NV] = '{
      56'h24_05_10_03_10_20_06, 56'h24_05_10_03_10_21_00,
      56'h00_01_01_00_00_00_00, 56'h24_02_29_03_00_00_00,
      56'h24_03_01_83_00_00_00, 56'h24_03_01_06_00_00_00,
      56'h23_03_01_31_00_00_00, 56'h23_05_01_32_00_00_00,
      56'h23_01_31_30_00_00_00, 56'h24_05_10_01_D2_00_00,
      56'h24_05_11_02_92_00_00, 56'h24_05_10_01_81_00_00,
      56'h24_05_10_01_C1_00_00, 56'h24_05_10_01_90_00_00,
      56'h24_05_10_01_10_00_00, 56'h24_05_10_01_10_21_00,
      56'h23_05_01_31_00_00_00
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        sec_tick;
   logic        clk_stop;
   logic        clk_adjust;
   logic [6:0]  wr_en;
   logic [55:0] wr_data;
   logic [7:0]  sec_o, min_o, hour_o, wk_o, day_o, mon_o, year_o;
   logic        busy_o;
   int          n_run  = 0;
   int          n_fail = 0;
   bit          done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rtc_calendar_core u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .sec_tick  (sec_tick),
      .clk_stop  (clk_stop),
      .clk_adjust(clk_adjust),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .sec_o     (sec_o),
      .min_o     (min_o),
      .hour_o    (hour_o),
      .wk_o      (wk_o),
      .day_o     (day_o),
      .mon_o     (mon_o),
      .year_o    (year_o),
      .busy_o    (busy_o)
   );

   function automatic logic [55:0] snap();
      return {year_o, mon_o, day_o, wk_o, hour_o, min_o, sec_o};
   endfunction

   function automatic string vreq(input int i);
      case (i)
         0:       return "R2";
         1:       return "R2";
         2:       return "R5 R8";
         3, 5:    return "R6";
         4, 6:    return "R6";
         7:       return "R5";
         8:       return "R7";
         9, 11:   return "R4";
         10, 12:  return "R4";
         13:      return "R4";
         14:      return "R3";
         default: return "R13";
      endcase
   endfunction

   task automatic chk(input string req, input logic [55:0] act, input logic [55:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [6:0] en, input logic [55:0] d);
      @(negedge clk);
      wr_en   = en;
      wr_data = d;
      @(negedge clk);
      wr_en   = '0;
   endtask

   task automatic tick();
      @(negedge clk);
      sec_tick = 1'b1;
      @(negedge clk);
      sec_tick = 1'b0;
   endtask

   task automatic pulse_adjust();
      @(negedge clk);
      clk_adjust = 1'b1;
      @(negedge clk);
      clk_adjust = 1'b0;
   endtask

   initial begin
      rst_n      = 1'b0;
      sec_tick   = 1'b0;
      clk_stop   = 1'b0;
      clk_adjust = 1'b0;
      wr_en      = '0;
      wr_data    = '0;
      wait_n(3);
      rst_n = 1'b1;
      wait_n(1);

      // R1 reset state
      chk("R1", snap(), 56'h00_01_01_00_00_00_00);
      chk("R1", {55'd0, busy_o}, 56'd0);

      // vector walk: load all bytes, one tick, compare
      for (int i = 0; i < NV; i++) begin
         wr(7'h7F, VIN[i]);
         tick();
         wait_n(LEAD);
         chk(vreq(i), snap(), VEXP[i]);
         wait_n(2);
      end

      // R11 busy framing around one advance
      wr(7'h01, 56'h00);
      tick();
      chk("R11", {55'd0, busy_o}, 56'd1);
      wait_n(LEAD - 1);
      chk("R11", {47'd0, busy_o, sec_o}, {47'd0, 1'b1, 8'h00});
      wait_n(1);
      chk("R11", {47'd0, busy_o, sec_o}, {47'd0, 1'b1, 8'h01});
      wait_n(1);
      chk("R11", {55'd0, busy_o}, 56'd0);

      // R9 clock stop swallows the tick
      clk_stop = 1'b1;
      tick();
      chk("R9", {55'd0, busy_o}, 56'd0);
      wait_n(20);
      chk("R9", {48'd0, sec_o}, {48'd0, 8'h01});
      clk_stop = 1'b0;

      // R10 adjust from the upper half rolls the whole calendar
      wr(7'h7F, 56'h95_12_31_33_23_59_45);
      pulse_adjust();
      chk("R10", snap(), 56'h96_01_01_04_00_00_00);
      // R10 adjust from the lower half only clears seconds
      wr(7'h7F, 56'h96_01_01_04_00_10_29);
      pulse_adjust();
      chk("R10", snap(), 56'h96_01_01_04_00_10_00);

      // R8 leap counter load and guarded direct write
      wr(7'h40, 56'h26_00_00_00_00_00_00);
      chk("R8", {48'd0, wk_o}, {48'd0, 8'h24});
      wr(7'h08, 56'h00_00_00_10_00_00_00);
      chk("R8", {48'd0, wk_o}, {48'd0, 8'h20});
      wr(7'h08, 56'h00_00_00_50_00_00_00);
      chk("R8", {48'd0, wk_o}, {48'd0, 8'h50});

      // R12 write lands in the commit cycle of an advance
      wr(7'h7F, 56'h96_01_01_04_00_10_59);
      tick();
      wait_n(LEAD - 1);
      wr_en   = 7'h01;
      wr_data = 56'h30;
      @(negedge clk);
      wr_en = '0;
      chk("R12", snap(), 56'h96_01_01_04_00_11_30);
      wait_n(2);

      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         done = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule